// File: doc/BRIEF.md
# Delayed Event and Data Staging Tracker

This block follows operations whose effect lands a fixed number of cycles after they are issued, such as a branch that takes hold several cycles later or a load whose result arrives late. Each channel owns a one-hot-per-slot event register that is `DELAY` bits long. A trigger places a token in the top slot. The token moves down one slot every clock and fires when it reaches slot zero, `DELAY` cycles after the trigger cycle. A channel can hold several tokens at once, one for each cycle in which it was triggered, and every token fires in its own cycle.

The fire bits of all channels are OR-merged into a single taken flag. Next to each event register runs a data lane. The value presented with a trigger is captured into the top staging register. The value then hops one staging register lower only in cycles when the event bit at its slot is set. In the cycle its token fires, the value is committed to one shared destination register. If several lanes commit in the same cycle, the lowest channel index wins. The destination register holds its value until the next commit.

Top module: `delay_event_tracker`

## Requirements
- R1: A trigger on channel c in cycle t makes `fire[c]` high in cycle t+DELAY and in no other cycle because of that trigger (DELAY=6 by default).
- R2: Triggers on the same channel in consecutive cycles are all kept; each fires exactly DELAY cycles after its own trigger cycle, including a trigger issued in the same cycle as an earlier token fires.
- R3: A trigger on one channel never causes a fire on any other channel.
- R4: `branch_taken` is high in exactly those cycles in which at least one bit of `fire` is high.
- R5: In the cycle a token fires, `commit_valid` is high for that one cycle and `commit_data` equals the `trig_data` slice of that channel (bits c*DATA_W up to c*DATA_W+DATA_W-1) that was sampled with the trigger.
- R6: When several channels fire in the same cycle, `commit_data` takes the value of the fired channel with the lowest index.
- R7: In cycles without a commit, `commit_valid` is low and `commit_data` keeps the last committed value, or zero if nothing has been committed since reset.
- R8: A synchronous active-high `rst` clears every event register, staging register and the destination register. Tokens in flight when reset is applied never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | NUM_CH | Per-channel trigger, sampled every cycle |
| trig_data | input | NUM_CH*DATA_W | Per-channel value captured with the trigger |
| fire | output | NUM_CH | Per-channel token arrival at slot zero |
| branch_taken | output | 1 | OR of all fire bits |
| commit_data | output | DATA_W | Destination register |
| commit_valid | output | 1 | One-cycle pulse when the destination is written |

## Verification
Two kinds of event can fall in the same cycle. The first is a new trigger on a channel in the cycle when an older token of that channel fires or shifts. The second is a commit from two or more lanes at once. The bench provokes both with bursts of back-to-back triggers on all channels and with a pseudo-random sweep of every trigger pattern. Each cycle it compares `fire`, `branch_taken`, `commit_valid` and `commit_data` against a timeline of recorded triggers delayed by DELAY, with the lowest fired channel choosing the expected data.

// File: rtl/dlyt_pkg.sv
package dlyt_pkg;
   // width needed to count from 0 up to and including n
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/dlyt_evt_chan.sv
module dlyt_evt_chan #(
   parameter int unsigned DELAY = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trig,
   output logic [DELAY-1:0] evt
);
   // shift toward slot zero, new token enters the top after the shift
   always_ff @(posedge clk) begin
      if (rst) evt <= '0;
      else     evt <= {trig, evt[DELAY-1:1]};
   end
endmodule

// File: rtl/dlyt_stage_lane.sv
module dlyt_stage_lane #(
   parameter int unsigned DELAY  = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig,
   input  logic [DATA_W-1:0] din,
   input  logic [DELAY-1:1]  evt,
   output logic              commit_en,
   output logic [DATA_W-1:0] commit_val
);
   logic [DATA_W-1:0] stg [DELAY-1:1];

   // top hop: capture together with the token insertion
   always_ff @(posedge clk) begin
      if (rst)       stg[DELAY-1] <= '0;
      else if (trig) stg[DELAY-1] <= din;
   end

   // lower hops: move only when the token sits one slot above
   for (genvar k = 1; k < DELAY - 1; k++) begin : g_hop
      always_ff @(posedge clk) begin
         if (rst)           stg[k] <= '0;
         else if (evt[k+1]) stg[k] <= stg[k+1];
      end
   end

   assign commit_en  = evt[1];
   assign commit_val = stg[1];
endmodule

// File: rtl/dlyt_commit_merge.sv
module dlyt_commit_merge #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_CH-1:0]        en,
   input  logic [NUM_CH*DATA_W-1:0] vals,
   output logic [DATA_W-1:0]        commit_data,
   output logic                     commit_valid
);
   logic [DATA_W-1:0] pick;
   logic              any;

   // walk from the top so the lowest enabled lane is the last one written
   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
         if (en[c]) begin
            pick = vals[c*DATA_W +: DATA_W];
            any  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         commit_data  <= '0;
         commit_valid <= 1'b0;
      end else begin
         commit_valid <= any;
         if (any) commit_data <= pick;
      end
   end
endmodule

// File: rtl/delay_event_tracker.sv
module delay_event_tracker #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned DELAY  = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_CH-1:0]        trig,
   input  logic [NUM_CH*DATA_W-1:0] trig_data,
   output logic [NUM_CH-1:0]        fire,
   output logic                     branch_taken,
   output logic [DATA_W-1:0]        commit_data,
   output logic                     commit_valid
);
   localparam int unsigned LANE_BITS = NUM_CH * DATA_W;

   if (DELAY < 2) begin : g_bad_delay
      $error("delay_event_tracker: DELAY must be at least 2");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("delay_event_tracker: NUM_CH must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("delay_event_tracker: DATA_W must be at least 1");
   end

   logic [NUM_CH-1:0]    lane_en;
   logic [LANE_BITS-1:0] lane_val;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DELAY-1:0] evt;

      dlyt_evt_chan #(.DELAY(DELAY)) u_evt (
         .clk  (clk),
         .rst  (rst),
         .trig (trig[c]),
         .evt  (evt)
      );

      dlyt_stage_lane #(.DELAY(DELAY), .DATA_W(DATA_W)) u_lane (
         .clk        (clk),
         .rst        (rst),
         .trig       (trig[c]),
         .din        (trig_data[c*DATA_W +: DATA_W]),
         .evt        (evt[DELAY-1:1]),
         .commit_en  (lane_en[c]),
         .commit_val (lane_val[c*DATA_W +: DATA_W])
      );

      assign fire[c] = evt[0];
   end

   assign branch_taken = |fire;

   dlyt_commit_merge #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_merge (
      .clk          (clk),
      .rst          (rst),
      .en           (lane_en),
      .vals         (lane_val),
      .commit_data  (commit_data),
      .commit_valid (commit_valid)
   );
endmodule

// File: rtl/dlyt_checker.sv
module dlyt_checker #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned DELAY  = 6,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [NUM_CH-1:0] fire,
   input logic              branch_taken,
   input logic [DATA_W-1:0] commit_data,
   input logic              commit_valid
);
   localparam int unsigned CW = dlyt_pkg::cnt_w(DELAY);

   logic [CW-1:0] since_rst;
   logic          primed;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= '0;
         primed    <= 1'b0;
      end else begin
         primed <= 1'b1;
         if (since_rst < CW'(DELAY)) since_rst <= since_rst + 1'b1;
      end
   end

   // R1: nothing can reach slot zero before DELAY non-reset edges
   p_no_early_fire_r1: assert property (@(posedge clk) disable iff (rst)
      (since_rst < CW'(DELAY)) |-> (fire == '0));

   // R4: merged flag follows the per-channel fire bits
   p_taken_merge_r4: assert property (@(posedge clk) disable iff (rst)
      branch_taken == (fire != '0));

   // R5: the commit register pulses exactly with a fire
   p_valid_tracks_fire_r5: assert property (@(posedge clk) disable iff (rst)
      commit_valid == (fire != '0));

   // R7: destination holds without a commit
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (primed && !commit_valid) |-> $stable(commit_data));

   // R8: the cycle after reset shows a cleared state
   p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (fire == '0 && !commit_valid && commit_data == '0));
endmodule

bind delay_event_tracker dlyt_checker #(
   .NUM_CH (NUM_CH),
   .DELAY  (DELAY),
   .DATA_W (DATA_W)
) u_dlyt_chk (
   .clk          (clk),
   .rst          (rst),
   .fire         (fire),
   .branch_taken (branch_taken),
   .commit_data  (commit_data),
   .commit_valid (commit_valid)
);

// File: tb/tb_delay_event_tracker.sv
`timescale 1ns/1ps
module tb_delay_event_tracker;
   localparam int NCH  = 3;
   localparam int DLY  = 6;
   localparam int DW   = 16;
   localparam int MAXS = 2048;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NCH-1:0]    trig = '0;
   logic [NCH*DW-1:0] trig_data = '0;
   logic [NCH-1:0]    fire;
   logic              branch_taken;
   logic [DW-1:0]     commit_data;
   logic              commit_valid;

   delay_event_tracker #(.NUM_CH(NCH), .DELAY(DLY), .DATA_W(DW)) dut (
      .clk(clk), .rst(rst), .trig(trig), .trig_data(trig_data),
      .fire(fire), .branch_taken(branch_taken),
      .commit_data(commit_data), .commit_valid(commit_valid)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int s = 0;
   string phase_tag = "R8";
   logic [NCH-1:0]    hist_t [MAXS];
   logic [NCH*DW-1:0] hist_d [MAXS];
   logic              hist_r [MAXS];
   logic [DW-1:0]     exp_last = '0;
   logic [15:0]       lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h (step %0d)", tag, what, act, exp, s);
      end
   endtask

   task automatic check_step();
      logic [NCH-1:0] ef;
      string tf, td;
      ef = (s >= DLY) ? hist_t[s-DLY] : '0;
      tf = phase_tag;
      if (hist_r[s-1]) begin
         exp_last = '0;
         tf = "R8";
      end
      chk(fire === ef, tf, "fire", 64'(fire), 64'(ef));
      chk(branch_taken === (ef != '0), "R4", "branch_taken", 64'(branch_taken), 64'(ef != '0));
      chk(commit_valid === (ef != '0), "R5", "commit_valid", 64'(commit_valid), 64'(ef != '0));
      td = hist_r[s-1] ? "R8" : "R7";
      if (ef != '0) begin
         td = ($countones(ef) > 1) ? "R6" : "R5";
         for (int c = NCH - 1; c >= 0; c--)
            if (ef[c]) exp_last = hist_d[s-DLY][c*DW +: DW];
      end
      chk(commit_data === exp_last, td, "commit_data", 64'(commit_data), 64'(exp_last));
   endtask

   task automatic tick(input logic [NCH-1:0] t, input logic [NCH*DW-1:0] d, input logic r);
      @(negedge clk);
      if (s >= 1) check_step();
      rst       = r;
      trig      = t;
      trig_data = d;
      hist_t[s] = r ? '0 : t;
      hist_d[s] = d;
      hist_r[s] = r;
      if (r) for (int k = 1; k < DLY && k <= s; k++) hist_t[s-k] = '0;
      s++;
   endtask

   function automatic logic [NCH*DW-1:0] mk_data(input int seed);
      logic [NCH*DW-1:0] v;
      for (int c = 0; c < NCH; c++) v[c*DW +: DW] = DW'(seed * 37 + c * 4099 + 1);
      return v;
   endfunction

   function automatic logic [15:0] lfsr_next(input logic [15:0] x);
      return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
   endfunction

   initial begin
      // R8: reset state
      phase_tag = "R8";
      for (int i = 0; i < 3; i++) tick('0, '0, 1'b1);
      // R1: single trigger per channel
      phase_tag = "R1";
      for (int c = 0; c < NCH; c++) begin
         tick(NCH'(1) << c, mk_data(c + 5), 1'b0);
         for (int i = 0; i < DLY + 2; i++) tick('0, mk_data(99), 1'b0);
      end
      // R3: only channel 1, irregular pattern
      phase_tag = "R3";
      for (int i = 0; i < 12; i++) tick((i % 3 != 2) ? 3'b010 : 3'b000, mk_data(200 + i), 1'b0);
      for (int i = 0; i < DLY + 2; i++) tick('0, '0, 1'b0);
      // R2: back-to-back on every channel, collisions drive R6
      phase_tag = "R2";
      for (int i = 0; i < 10; i++) tick('1, mk_data(300 + i), 1'b0);
      for (int i = 0; i < DLY + 4; i++) tick('0, '0, 1'b0);
      // sweep over all trigger patterns
      phase_tag = "R2";
      for (int i = 0; i < 600; i++) begin
         lfsr = lfsr_next(lfsr);
         tick(lfsr[2:0], {lfsr, ~lfsr, lfsr ^ 16'h5A5A}, 1'b0);
      end
      for (int i = 0; i < DLY + 2; i++) tick('0, '0, 1'b0);
      // R8: reset with tokens in flight
      phase_tag = "R8";
      for (int i = 0; i < 3; i++) tick('1, mk_data(400 + i), 1'b0);
      tick('0, '0, 1'b1);
      for (int i = 0; i < DLY + 4; i++) tick('0, '0, 1'b0);
      tick('0, '0, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule